// File: doc/BRIEF.md
# Clustered Thread-Priority Memory Request Scheduler

This block chooses which pending DRAM request to issue next from a request buffer shared by several hardware threads. Each buffer slot carries a thread number, a bank, a row and an age. The scheduler also receives the open-row state of every bank. In every cycle where at least one slot is valid, it grants exactly one slot. The chosen slot is reported combinationally, so the requester can retire it at the next clock edge.

Grants are counted per thread over a quantum whose length is programmable. When a quantum closes, the threads are split into two clusters. Threads are taken in order of increasing grant count and placed in a light cluster for as long as their running sum of grants stays within a programmable fraction of all grants in that quantum. Every other thread goes to a heavy cluster.

Light threads always outrank heavy threads, and among light threads the one with fewer grants ranks higher. This favours throughput. The heavy cluster starts out ordered by intensity, and its ranking is rotated by one place every shuffle interval, so that no heavy thread keeps the top heavy rank. Within a rank, a request that hits an open row beats one that misses, and an older request beats a younger one.

Top module: `cluster_sched`

## Requirements
- R1: `grant_valid` is 1 in a cycle if and only if at least one bit of `req_valid` is 1. When it is 1, `grant_idx` names a valid slot.
- R2: Among valid slots, a slot whose thread has a better (lower) rank is granted over any slot of a worse-ranked thread, whatever their row-hit status or age.
- R3: Between slots of equal thread rank, a row hit is granted over a miss. A slot is a hit only when `bank_open[bank]` is 1 and `bank_row[bank]` equals the slot's row. A matching row in a closed bank is a miss.
- R4: Between slots of equal rank and equal hit status, the larger `req_age` value (older) wins. A full tie goes to the lowest slot index.
- R5: A thread's intensity is the number of grants it receives during one quantum of `cfg_quantum` cycles. The first quantum starts on the first clock edge after reset. Clusters are rebuilt on the last edge of each quantum and take effect from the next cycle. Until then, the previous clusters stay in force.
- R6: At rebuild, threads are ordered by ascending grant count, with ties going to the lower thread number. A thread is light when 16 × (its own count plus the counts of all threads before it) ≤ `cfg_threshold` × (total count). All other threads are heavy. A quantum with no grants makes every thread light.
- R7: Every light thread outranks every heavy thread. Light threads rank in the R6 order, lightest first.
- R8: Heavy threads start each quantum ranked in R6 order. On the edge that ends each `cfg_shuffle`-cycle interval (the first interval starting at the quantum start), the heavy ranking rotates by one place: the top heavy thread drops to the bottom and the others move up one. A cluster with fewer than two heavy threads does not rotate.
- R9: After reset, all threads are light and rank in thread-number order (thread 0 highest).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | BUF_DEPTH | Slot holds a pending request |
| req_tid | input | BUF_DEPTH*TID_W | Thread number per slot |
| req_bank | input | BUF_DEPTH*BANK_W | Target bank per slot |
| req_row | input | BUF_DEPTH*ROW_W | Target row per slot |
| req_age | input | BUF_DEPTH*AGE_W | Age per slot, larger is older |
| bank_open | input | NUM_BANKS | Bank has an open row |
| bank_row | input | NUM_BANKS*ROW_W | Currently open row per bank |
| cfg_quantum | input | TIMER_W | Quantum length in cycles |
| cfg_threshold | input | 4 | Light-cluster share in sixteenths |
| cfg_shuffle | input | TIMER_W | Heavy-rank rotation interval in cycles |
| grant_valid | output | 1 | A slot is granted this cycle |
| grant_idx | output | IDX_W | Granted slot index |

## Verification
The assertions assume that the three configuration inputs hold still while the block is out of reset. The timer checks compare the cycle counters against those values. They also assume that the requester removes or keeps slots only between clock edges, never within a cycle.

The bench changes configuration only while reset is held. It drives the buffer on falling edges and makes all combinational grant observations inside one low clock phase. It reaches known grant counts by holding a single slot of one thread for an exact number of cycles. Expected cluster membership and rotated orders are then computed arithmetically and compared by draining a four-slot buffer one winner at a time.

// File: rtl/csch_pkg.sv
// Package for the clustered scheduler: shared constants and helpers.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package csch_pkg;

    // Threshold is a fraction expressed in sixteenths.
    localparam int unsigned THR_W = 4;

    // Saturating increment of an unsigned counter value.
    function automatic logic [31:0] sat_inc(input logic [31:0] value, input logic [31:0] max_value);
        return (value >= max_value) ? max_value : value + 32'd1;
    endfunction

endpackage

// File: rtl/csch_intensity.sv
// Per-thread intensity meter. Counts grants per thread over a quantum of
// cfg_quantum cycles and flags the last cycle of each quantum. The count
// including the current cycle's grant is exported for cluster rebuilding.
// Assumes cfg_quantum is static while out of reset.
module csch_intensity #(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W       = 10,
    parameter int TIMER_W     = 16,
    localparam int TID_W      = $clog2(NUM_THREADS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                grant_valid,
    input  logic [TID_W-1:0]                    grant_tid,
    input  logic [TIMER_W-1:0]                  cfg_quantum,
    output logic                                quantum_end,
    output logic [NUM_THREADS-1:0][CNT_W-1:0]   cnt_final
);
    import csch_pkg::*;

    localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 64'd1);

    logic [NUM_THREADS-1:0][CNT_W-1:0] cnt_q;
    logic [TIMER_W-1:0]                q_cnt;

    // Quantum closes when the cycle counter reaches the programmed length.
    assign quantum_end = ({1'b0, q_cnt} + {{TIMER_W{1'b0}}, 1'b1}) >= {1'b0, cfg_quantum};

    // Count including this cycle's grant, saturating at the counter width.
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (grant_valid && grant_tid == TID_W'(t))
                cnt_final[t] = CNT_W'(sat_inc(32'(cnt_q[t]), CNT_MAX));
            else
                cnt_final[t] = cnt_q[t];
        end
    end

    // Advance the quantum timer and the per-thread counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_cnt <= '0;
            cnt_q <= '0;
        end else if (quantum_end) begin
            q_cnt <= '0;
            cnt_q <= '0;
        end else begin
            q_cnt <= q_cnt + TIMER_W'(1);
            cnt_q <= cnt_final;
        end
    end

    AST_QUANTUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_quantum != '0) |-> (q_cnt < cfg_quantum)); // R5

    generate
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_cnt_chk
            AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
                quantum_end |=> (cnt_q[t] == '0)); // R5
        end
    endgenerate

endmodule

// File: rtl/csch_cluster.sv
// Cluster builder. At each quantum end it orders threads by grant count
// (ties to lower thread number) and marks the prefix whose running sum stays
// within cfg_threshold/16 of the total as light. Holds the result until the
// next quantum end. Assumes NUM_THREADS is at least 2.
module csch_cluster #(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W       = 10,
    localparam int TID_W      = $clog2(NUM_THREADS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                update,
    input  logic [NUM_THREADS-1:0][CNT_W-1:0]   snap,
    input  logic [csch_pkg::THR_W-1:0]          cfg_threshold,
    output logic [NUM_THREADS-1:0]              light_q,
    output logic [NUM_THREADS-1:0][TID_W-1:0]   pos_q,
    output logic [TID_W:0]                      num_light_q
);
    import csch_pkg::*;

    localparam int SUM_W   = CNT_W + TID_W + 1;
    localparam int SCALE_W = SUM_W + THR_W;

    logic [NUM_THREADS-1:0]            light_n;
    logic [NUM_THREADS-1:0][TID_W-1:0] pos_n;
    logic [TID_W:0]                    num_light_n;
    logic [SUM_W-1:0]                  total;
    logic [TID_W:0]                    pos_acc;
    logic [SUM_W-1:0]                  sum_acc;
    logic [NUM_THREADS-1:0][CNT_W-1:0] cnt_q;

    // Rank every thread and test its running sum against the threshold.
    always_comb begin
        total = '0;
        for (int j = 0; j < NUM_THREADS; j++)
            total = total + SUM_W'(snap[j]);
        num_light_n = '0;
        light_n     = '0;
        pos_n       = '0;
        pos_acc     = '0;
        sum_acc     = '0;
        for (int i = 0; i < NUM_THREADS; i++) begin
            pos_acc = '0;
            sum_acc = SUM_W'(snap[i]);
            for (int j = 0; j < NUM_THREADS; j++) begin
                if (j != i && ((snap[j] < snap[i]) || (snap[j] == snap[i] && j < i))) begin
                    pos_acc = pos_acc + (TID_W+1)'(1);
                    sum_acc = sum_acc + SUM_W'(snap[j]);
                end
            end
            pos_n[i]    = pos_acc[TID_W-1:0];
            light_n[i]  = ((SCALE_W'(sum_acc) << THR_W) <=
                           (SCALE_W'(total) * SCALE_W'(cfg_threshold)));
            num_light_n = num_light_n + {{TID_W{1'b0}}, light_n[i]};
        end
    end

    // Latch the new clusters at quantum end; reset makes all threads light.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            light_q     <= '1;
            num_light_q <= (TID_W+1)'(NUM_THREADS);
            cnt_q       <= '0;
            for (int i = 0; i < NUM_THREADS; i++)
                pos_q[i] <= TID_W'(i);
        end else if (update) begin
            light_q     <= light_n;
            pos_q       <= pos_n;
            num_light_q <= num_light_n;
            cnt_q       <= snap;
        end
    end

    generate
        for (genvar i = 0; i < NUM_THREADS; i++) begin : g_li
            for (genvar j = 0; j < NUM_THREADS; j++) begin : g_hj
                AST_LIGHT_NOT_HEAVIER: assert property (@(posedge clk) disable iff (!rst_n)
                    (light_q[i] && !light_q[j]) |-> (cnt_q[i] <= cnt_q[j])); // R6
            end
        end
    endgenerate

endmodule

// File: rtl/csch_rank.sv
// Rank generator. Light threads take ranks from their cluster order; heavy
// threads take the ranks behind them, rotated by an offset that advances
// every cfg_shuffle cycles and restarts at each quantum end.
// Assumes cfg_shuffle is static while out of reset.
module csch_rank #(
    parameter int NUM_THREADS = 4,
    parameter int TIMER_W     = 16,
    localparam int TID_W      = $clog2(NUM_THREADS),
    localparam int PRIO_W     = TID_W + 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                quantum_end,
    input  logic [TIMER_W-1:0]                  cfg_shuffle,
    input  logic [NUM_THREADS-1:0]              light_q,
    input  logic [NUM_THREADS-1:0][TID_W-1:0]   pos_q,
    input  logic [TID_W:0]                      num_light_q,
    output logic [NUM_THREADS-1:0][PRIO_W-1:0]  thread_prio
);
    logic [TIMER_W-1:0] s_cnt;
    logic [TID_W:0]     offset;
    logic [TID_W:0]     num_heavy;
    logic               tick;
    logic [TID_W:0]     heavy_idx [NUM_THREADS];
    logic [TID_W:0]     rot       [NUM_THREADS];

    assign num_heavy = (TID_W+1)'(NUM_THREADS) - num_light_q;
    assign tick      = ({1'b0, s_cnt} + {{TIMER_W{1'b0}}, 1'b1}) >= {1'b0, cfg_shuffle};

    // Form each thread's rank: cluster bit on top, position or rotated slot below.
    always_comb begin
        for (int i = 0; i < NUM_THREADS; i++) begin
            heavy_idx[i] = {1'b0, pos_q[i]} - num_light_q;
            if (heavy_idx[i] >= offset)
                rot[i] = heavy_idx[i] - offset;
            else
                rot[i] = heavy_idx[i] + num_heavy - offset;
            if (light_q[i])
                thread_prio[i] = {1'b0, pos_q[i]};
            else
                thread_prio[i] = {1'b1, rot[i][TID_W-1:0]};
        end
    end

    // Shuffle timer and rotation offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_cnt  <= '0;
            offset <= '0;
        end else if (quantum_end) begin
            s_cnt  <= '0;
            offset <= '0;
        end else if (tick) begin
            s_cnt <= '0;
            if (num_heavy <= (TID_W+1)'(1) || offset + (TID_W+1)'(1) >= num_heavy)
                offset <= '0;
            else
                offset <= offset + (TID_W+1)'(1);
        end else begin
            s_cnt <= s_cnt + TIMER_W'(1);
        end
    end

    AST_OFFSET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (num_heavy != '0) |-> (offset < num_heavy)); // R8

    AST_ROTATION_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !quantum_end && num_heavy > (TID_W+1)'(1)) |=> (offset != $past(offset))); // R8

endmodule

// File: rtl/csch_arbiter.sv
// Request picker. Scans the buffer and keeps the best valid slot by
// (thread rank, row hit, age), first slot winning full ties. Purely
// combinational; clock and reset feed only its assertions.
module csch_arbiter #(
    parameter int NUM_THREADS = 4,
    parameter int BUF_DEPTH   = 8,
    parameter int NUM_BANKS   = 4,
    parameter int ROW_W       = 8,
    parameter int AGE_W       = 8,
    localparam int TID_W      = $clog2(NUM_THREADS),
    localparam int IDX_W      = $clog2(BUF_DEPTH),
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int PRIO_W     = TID_W + 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [BUF_DEPTH-1:0]                req_valid,
    input  logic [BUF_DEPTH*TID_W-1:0]          req_tid,
    input  logic [BUF_DEPTH*BANK_W-1:0]         req_bank,
    input  logic [BUF_DEPTH*ROW_W-1:0]          req_row,
    input  logic [BUF_DEPTH*AGE_W-1:0]          req_age,
    input  logic [NUM_BANKS-1:0]                bank_open,
    input  logic [NUM_BANKS*ROW_W-1:0]          bank_row,
    input  logic [NUM_THREADS-1:0][PRIO_W-1:0]  thread_prio,
    output logic                                grant_valid,
    output logic [IDX_W-1:0]                    grant_idx,
    output logic [TID_W-1:0]                    grant_tid
);
    logic [BUF_DEPTH-1:0] hit;
    logic [PRIO_W-1:0]    best_prio;
    logic                 best_hit;
    logic [AGE_W-1:0]     best_age;
    logic [PRIO_W-1:0]    cur_prio;
    logic [AGE_W-1:0]     cur_age;
    logic [BANK_W-1:0]    cur_bank;
    logic                 better;

    // Row-hit test of every slot against its bank's open row.
    always_comb begin
        for (int e = 0; e < BUF_DEPTH; e++) begin
            cur_bank = req_bank[e*BANK_W +: BANK_W];
            hit[e]   = bank_open[cur_bank] &&
                       (bank_row[cur_bank*ROW_W +: ROW_W] == req_row[e*ROW_W +: ROW_W]);
        end
    end

    // Linear scan keeping the best candidate.
    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        grant_tid   = '0;
        best_prio   = '0;
        best_hit    = 1'b0;
        best_age    = '0;
        cur_prio    = '0;
        cur_age     = '0;
        better      = 1'b0;
        for (int e = 0; e < BUF_DEPTH; e++) begin
            cur_prio = thread_prio[req_tid[e*TID_W +: TID_W]];
            cur_age  = req_age[e*AGE_W +: AGE_W];
            better   = (cur_prio < best_prio) ||
                       (cur_prio == best_prio && hit[e] && !best_hit) ||
                       (cur_prio == best_prio && hit[e] == best_hit && cur_age > best_age);
            if (req_valid[e] && (!grant_valid || better)) begin
                grant_valid = 1'b1;
                grant_idx   = IDX_W'(e);
                grant_tid   = req_tid[e*TID_W +: TID_W];
                best_prio   = cur_prio;
                best_hit    = hit[e];
                best_age    = cur_age;
            end
        end
    end

    AST_GRANT_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> req_valid[grant_idx]); // R1

    generate
        for (genvar e = 0; e < BUF_DEPTH; e++) begin : g_rank_chk
            AST_GRANT_TOP_RANK: assert property (@(posedge clk) disable iff (!rst_n)
                (grant_valid && req_valid[e]) |->
                (thread_prio[req_tid[e*TID_W +: TID_W]] >= thread_prio[grant_tid])); // R2
        end
    endgenerate

endmodule

// File: rtl/cluster_sched.sv
// Clustered thread-priority request scheduler (top). Wires the intensity
// meter, cluster builder, rank generator and picker. Grants are
// combinational; the requester retires the granted slot at the next edge.
// Assumes configuration inputs are static while out of reset.
module cluster_sched #(
    parameter int NUM_THREADS = 4,
    parameter int BUF_DEPTH   = 8,
    parameter int NUM_BANKS   = 4,
    parameter int ROW_W       = 8,
    parameter int AGE_W       = 8,
    parameter int CNT_W       = 10,
    parameter int TIMER_W     = 16,
    localparam int TID_W      = $clog2(NUM_THREADS),
    localparam int IDX_W      = $clog2(BUF_DEPTH),
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int PRIO_W     = TID_W + 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [BUF_DEPTH-1:0]              req_valid,
    input  logic [BUF_DEPTH*TID_W-1:0]        req_tid,
    input  logic [BUF_DEPTH*BANK_W-1:0]       req_bank,
    input  logic [BUF_DEPTH*ROW_W-1:0]        req_row,
    input  logic [BUF_DEPTH*AGE_W-1:0]        req_age,
    input  logic [NUM_BANKS-1:0]              bank_open,
    input  logic [NUM_BANKS*ROW_W-1:0]        bank_row,
    input  logic [TIMER_W-1:0]                cfg_quantum,
    input  logic [csch_pkg::THR_W-1:0]        cfg_threshold,
    input  logic [TIMER_W-1:0]                cfg_shuffle,
    output logic                              grant_valid,
    output logic [IDX_W-1:0]                  grant_idx
);
    logic                                quantum_end;
    logic [NUM_THREADS-1:0][CNT_W-1:0]   cnt_final;
    logic [NUM_THREADS-1:0]              light_q;
    logic [NUM_THREADS-1:0][TID_W-1:0]   pos_q;
    logic [TID_W:0]                      num_light_q;
    logic [NUM_THREADS-1:0][PRIO_W-1:0]  thread_prio;
    logic [TID_W-1:0]                    grant_tid;

    csch_intensity #(
        .NUM_THREADS (NUM_THREADS),
        .CNT_W       (CNT_W),
        .TIMER_W     (TIMER_W)
    ) u_intensity (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_valid (grant_valid),
        .grant_tid   (grant_tid),
        .cfg_quantum (cfg_quantum),
        .quantum_end (quantum_end),
        .cnt_final   (cnt_final)
    );

    csch_cluster #(
        .NUM_THREADS (NUM_THREADS),
        .CNT_W       (CNT_W)
    ) u_cluster (
        .clk           (clk),
        .rst_n         (rst_n),
        .update        (quantum_end),
        .snap          (cnt_final),
        .cfg_threshold (cfg_threshold),
        .light_q       (light_q),
        .pos_q         (pos_q),
        .num_light_q   (num_light_q)
    );

    csch_rank #(
        .NUM_THREADS (NUM_THREADS),
        .TIMER_W     (TIMER_W)
    ) u_rank (
        .clk         (clk),
        .rst_n       (rst_n),
        .quantum_end (quantum_end),
        .cfg_shuffle (cfg_shuffle),
        .light_q     (light_q),
        .pos_q       (pos_q),
        .num_light_q (num_light_q),
        .thread_prio (thread_prio)
    );

    csch_arbiter #(
        .NUM_THREADS (NUM_THREADS),
        .BUF_DEPTH   (BUF_DEPTH),
        .NUM_BANKS   (NUM_BANKS),
        .ROW_W       (ROW_W),
        .AGE_W       (AGE_W)
    ) u_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_tid     (req_tid),
        .req_bank    (req_bank),
        .req_row     (req_row),
        .req_age     (req_age),
        .bank_open   (bank_open),
        .bank_row    (bank_row),
        .thread_prio (thread_prio),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .grant_tid   (grant_tid)
    );

endmodule

// File: tb/test_cluster_sched.sv
`timescale 1ns/100ps
// Bench for cluster_sched: directed arbitration cases plus cluster and
// rotation sweeps whose expected orders are computed arithmetically.
module test_cluster_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req_valid = '0;
    logic [15:0] req_tid = '0;
    logic [15:0] req_bank = '0;
    logic [63:0] req_row = '0;
    logic [63:0] req_age = '0;
    logic [3:0]  bank_open = 4'b0001;
    logic [31:0] bank_row = {8'd0, 8'd0, 8'd5, 8'd5};
    logic [15:0] cfg_quantum = 16'hFFFF;
    logic [3:0]  cfg_threshold = 4'd8;
    logic [15:0] cfg_shuffle = 16'hFFFF;
    logic        grant_valid;
    logic [2:0]  grant_idx;

    int checks = 0;
    int errors = 0;
    int cnt_m [4];
    int ord_m [4];

    cluster_sched i_cluster_sched (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_tid (req_tid), .req_bank (req_bank),
        .req_row (req_row), .req_age (req_age),
        .bank_open (bank_open), .bank_row (bank_row),
        .cfg_quantum (cfg_quantum), .cfg_threshold (cfg_threshold),
        .cfg_shuffle (cfg_shuffle),
        .grant_valid (grant_valid), .grant_idx (grant_idx)
    );

    always #2 clk = ~clk;

    // Record one comparison of granted slot against the expected one.
    task automatic chk(input string tag, input logic exp_v, input int exp_idx);
        checks++;
        if (grant_valid !== exp_v || (exp_v && int'(grant_idx) != exp_idx)) begin
            errors++;
            $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
                     tag, grant_valid, grant_idx, exp_v, exp_idx);
        end
    endtask

    task automatic set_slot(input int e, input int tid, input int bank, input int row, input int age);
        req_valid[e]        = 1'b1;
        req_tid[e*2 +: 2]   = 2'(tid);
        req_bank[e*2 +: 2]  = 2'(bank);
        req_row[e*8 +: 8]   = 8'(row);
        req_age[e*8 +: 8]   = 8'(age);
    endtask

    // Expected ranking from counts, threshold and number of rotation ticks.
    task automatic compute_order(input int thr, input int ticks);
        int pos [4];
        int sum [4];
        bit lt  [4];
        int total, nl, nh, off, key;
        total = 0;
        for (int i = 0; i < 4; i++) total += cnt_m[i];
        nl = 0;
        for (int i = 0; i < 4; i++) begin
            pos[i] = 0;
            sum[i] = cnt_m[i];
            for (int j = 0; j < 4; j++)
                if (j != i && (cnt_m[j] < cnt_m[i] || (cnt_m[j] == cnt_m[i] && j < i))) begin
                    pos[i]++;
                    sum[i] += cnt_m[j];
                end
            lt[i] = (16 * sum[i] <= thr * total);
            if (lt[i]) nl++;
        end
        nh  = 4 - nl;
        off = (nh > 1) ? ticks % nh : 0;
        for (int i = 0; i < 4; i++) begin
            if (lt[i]) key = pos[i];
            else key = nl + (((pos[i] - nl - off) % nh) + nh) % nh;
            ord_m[key] = i;
        end
    endtask

    // Drain four slots (slot t holds thread t) inside one low clock phase.
    task automatic check_order(input string tag);
        req_valid = '0;
        for (int t = 0; t < 4; t++)
            set_slot(t, t, 0, (t % 2 == 0) ? 5 : 9, 40 - 10 * t);
        for (int k = 0; k < 4; k++) begin
            #0.3;
            chk($sformatf("%s rank %0d", tag, k), 1'b1, ord_m[k]);
            req_valid[ord_m[k]] = 1'b0;
        end
        req_valid = '0;
    endtask

    // Reset, then give each thread an exact number of grants in one quantum.
    task automatic run_scenario(input int c0, input int c1, input int c2, input int c3,
                                input int thr, input string tag);
        rst_n = 1'b0;
        req_valid = '0;
        cfg_quantum = 16'd20;
        cfg_shuffle = 16'd6;
        cfg_threshold = 4'(thr);
        cnt_m[0] = c0; cnt_m[1] = c1; cnt_m[2] = c2; cnt_m[3] = c3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < 4; t++) begin
            if (cnt_m[t] > 0) begin
                req_valid = '0;
                set_slot(0, t, 2, 1, 1);
                repeat (cnt_m[t]) @(posedge clk);
                @(negedge clk);
            end
        end
        req_valid = '0;
        // R5 R6 R7: rebuilt clusters apply right after the quantum's last edge
        compute_order(thr, 0);
        check_order({tag, " R6 R7 new clusters"});
        repeat (6) @(posedge clk);
        @(negedge clk);
        compute_order(thr, 1);
        check_order({tag, " R8 first rotation"});
        repeat (6) @(posedge clk);
        @(negedge clk);
        compute_order(thr, 2);
        check_order({tag, " R8 second rotation"});
        repeat (6) @(posedge clk);
        @(negedge clk);
        compute_order(thr, 3);
        check_order({tag, " R8 third rotation"});
        repeat (1) @(posedge clk);
        @(negedge clk);
        // R5: one cycle before the quantum ends, the old clusters still hold
        check_order({tag, " R5 before rebuild"});
        repeat (1) @(posedge clk);
        @(negedge clk);
        // R6: idle quantum makes every thread light in thread order
        cnt_m[0] = 0; cnt_m[1] = 0; cnt_m[2] = 0; cnt_m[3] = 0;
        compute_order(thr, 0);
        check_order({tag, " R6 idle quantum"});
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL R1 watchdog: run still active, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        chk("R1 empty buffer after reset", 1'b0, 0);
        // R9: reset ranking is thread-number order
        cnt_m[0] = 0; cnt_m[1] = 0; cnt_m[2] = 0; cnt_m[3] = 0;
        compute_order(8, 0);
        check_order("R9 reset order");

        @(negedge clk);
        set_slot(2, 1, 0, 9, 1); set_slot(5, 0, 0, 9, 1);
        #0.5 chk("R2 better thread rank wins", 1'b1, 5);
        req_valid = '0;

        @(negedge clk);
        set_slot(1, 2, 0, 9, 50); set_slot(3, 2, 0, 5, 1);
        #0.5 chk("R3 row hit beats older miss", 1'b1, 3);
        req_valid = '0;

        @(negedge clk);
        set_slot(0, 1, 0, 9, 3); set_slot(6, 1, 0, 9, 9);
        #0.5 chk("R4 older request wins", 1'b1, 6);
        req_valid = '0;

        @(negedge clk);
        set_slot(4, 3, 0, 9, 7); set_slot(7, 3, 0, 9, 7);
        #0.5 chk("R4 full tie lowest slot", 1'b1, 4);
        req_valid = '0;

        @(negedge clk);
        set_slot(0, 3, 0, 5, 200); set_slot(7, 0, 0, 9, 0);
        #0.5 chk("R2 rank beats hit and age", 1'b1, 7);
        req_valid = '0;

        @(negedge clk);
        set_slot(2, 1, 1, 5, 1); set_slot(3, 1, 0, 9, 2);
        #0.5 chk("R3 closed bank is a miss", 1'b1, 3);
        req_valid = '0;

        @(negedge clk);
        set_slot(6, 2, 3, 0, 0);
        #0.5 chk("R1 single valid slot", 1'b1, 6);
        req_valid = '0;
        #0.3 chk("R1 no grant when empty", 1'b0, 0);

        // three heavy threads rotate through all offsets
        run_scenario(2, 3, 5, 10, 2, "scnA");
        // equal counts: ties ordered by thread number, two heavy threads
        run_scenario(5, 5, 5, 5, 8, "scnB");
        // unordered counts with a zero: single heavy thread never rotates
        run_scenario(10, 0, 6, 4, 15, "scnC");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule